// File: doc/BRIEF.md
# Parallel-Bus Converter Control Sequencer

This block is the digital control core of a 12-bit sampling converter that sits on a shared parallel bus. A host writes an 8-bit control word by pulsing the write strobe while chip select is low. The word sets the power state, the conversion clock source, the acquisition style, the input mode and the channel address. The block then steps through tracking, hold and conversion. It tells a separate successive-approximation engine when to start and when each bit step occurs. It captures that engine's result, flags completion on an active-low interrupt, and puts the result on the bus during a read.

Acquisition can be self-timed: tracking lasts four converter clock ticks after the write. It can also be host-timed: a first write opens tracking and a second write closes it and starts conversion. The converter clock is either an external clock-enable pulse, which only counts while chip select is low, or an internal tick input that stands in for an on-chip oscillator. The tri-state bus is split into a data input, a data output and an output enable.

Top module: `adc_bus_seq`

## Requirements
- R1: After reset, int_n is 1, clk_ext is 1 (external ticks selected), pwr_state is 0 (active), tracking is 0, corrupt is 0 and bus_oe is 0.
- R2: A write event latches bus_din. Bits 7:6 are the power/clock code and bit 5 selects host-timed acquisition. Bit 4 (1 = single-ended) drives single_ended, bit 3 (1 = unipolar) drives unipolar, and bits 2:0 drive ch_addr.
- R3: A write with code 1x and bit 5 = 0 raises tracking. On the 4th converter tick, tracking drops and conv_start pulses. On the 13th tick after that, int_n falls and the sar_result value is captured.
- R4: A write with code 1x and bit 5 = 1 holds tracking high for any number of ticks. The next write with bit 5 = 0 drops tracking, pulses conv_start, and begins a 13-tick conversion.
- R5: If that closing write differs from the opening write in bits 4:0, corrupt rises. The conversion's result is discarded: int_n stays 1 and the bus keeps the old result. A difference in bits 7:6 alone is allowed.
- R6: A write during acquisition or conversion abandons the current conversion and starts a fresh acquisition. Only the new conversion completes.
- R7: int_n returns to 1 on the first read (falling read strobe with chip select low) or on any write event.
- R8: bus_oe is 1 exactly while cs_n and rd_n are both 0, and bus_dout then carries the last captured result.
- R9: While cs_n is 1, the write strobe, the read strobe and the external tick have no effect.
- R10: Code 11 selects the external tick (clk_ext = 1) and code 10 selects the internal tick (clk_ext = 0). The unselected tick is ignored. Codes 00 and 01 leave the clock choice unchanged.
- R11: Code 00 sets pwr_state to 2 (shutdown) and code 01 sets it to 1 (standby). Neither starts tracking or conversion. A later write with code 1x returns pwr_state to 0.
- R12: A power-down code on the write that closes host-timed acquisition still lets that conversion finish and raise the interrupt, while pwr_state shows the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; rising edge latches the control word |
| rd_n | input | 1 | Read strobe, active low |
| bus_din | input | 8 | Control word from the bus |
| bus_dout | output | DATA_W | Result toward the bus |
| bus_oe | output | 1 | Bus drive enable |
| int_n | output | 1 | Result-ready interrupt, active low |
| ext_tick | input | 1 | External converter clock enable (one pulse per clock) |
| int_tick | input | 1 | Internal oscillator tick |
| sar_result | input | DATA_W | Result presented by the SAR engine |
| tracking | output | 1 | Track/hold is in track |
| conv_start | output | 1 | One-cycle pulse at the hold instant / conversion start |
| conv_step | output | 1 | One-cycle pulse for each conversion clock |
| ch_addr | output | 3 | Latched channel address |
| single_ended | output | 1 | Latched input mode |
| unipolar | output | 1 | Latched range mode |
| clk_ext | output | 1 | 1 when external ticks drive the sequence |
| pwr_state | output | 2 | 0 active, 1 standby, 2 shutdown |
| corrupt | output | 1 | Closing write changed a protected field |

## Verification
The assertions assume the host treats the strobes as synchronous levels held for at least one system clock. They also assume a write strobe never rises in the same cycle as a converter tick and that reset holds both strobes high. The stimulus keeps to these rules by changing every input on the falling clock edge. Each strobe is held for one whole cycle, and tick pulses are issued one at a time, only between bus transactions. Chip select is moved only while both strobes are idle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    PS_ACTIVE   = 2'd0,
    PS_STANDBY  = 2'd1,
    PS_SHUTDOWN = 2'd2
  } pwr_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACQ_SELF,
    PH_ACQ_HOST,
    PH_CONV
  } phase_e;

  // control word, bit 7 down to bit 0
  typedef struct packed {
    logic [1:0] pmode;
    logic       host_acq;
    logic       single;
    logic       uni;
    logic [2:0] addr;
  } ctrl_t;
endpackage

// File: rtl/adc_bus_front.sv
module adc_bus_front
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              ext_tick,
  input  logic              int_tick,
  input  logic              use_ext,
  input  logic [CTRL_W-1:0] din,
  output logic              wr_ev,
  output logic              rd_ev,
  output ctrl_t             wr_word,
  output logic              tick
);
  logic wr_q, rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  assign wr_ev   = !cs_n && !wr_q && wr_n;
  assign rd_ev   = !cs_n && rd_q && !rd_n;
  assign wr_word = ctrl_t'(din);
  assign tick    = use_ext ? (ext_tick && !cs_n) : int_tick;
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int ACQ_TICKS  = 4,
  parameter int CONV_TICKS = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ev,
  input  ctrl_t      wr_word,
  input  logic       tick,
  output logic [4:0] sel_q,
  output logic       use_ext,
  output pwr_e       pwr_q,
  output logic       tracking,
  output logic       conv_start,
  output logic       conv_step,
  output logic       corrupt,
  output logic       done_now
);
  localparam int MAXT = (CONV_TICKS > ACQ_TICKS) ? CONV_TICKS : ACQ_TICKS;
  localparam int CW   = $clog2(MAXT) + 1;
  localparam logic [CW-1:0] ACQ_LAST  = CW'(ACQ_TICKS - 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_TICKS - 1);

  phase_e        phase;
  logic [CW-1:0] cnt;

  assign done_now = !wr_ev && tick && (phase == PH_CONV) && (cnt == CONV_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      sel_q      <= '0;
      use_ext    <= 1'b1;
      pwr_q      <= PS_ACTIVE;
      tracking   <= 1'b0;
      conv_start <= 1'b0;
      conv_step  <= 1'b0;
      corrupt    <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      conv_step  <= 1'b0;
      if (wr_ev) begin
        sel_q   <= wr_word[4:0];
        corrupt <= 1'b0;
        cnt     <= '0;
        if (wr_word.pmode[1]) use_ext <= wr_word.pmode[0];
        case (wr_word.pmode)
          2'b00:   pwr_q <= PS_SHUTDOWN;
          2'b01:   pwr_q <= PS_STANDBY;
          default: pwr_q <= PS_ACTIVE;
        endcase
        if (phase == PH_ACQ_HOST && !wr_word.host_acq) begin
          phase      <= PH_CONV;
          tracking   <= 1'b0;
          conv_start <= 1'b1;
          corrupt    <= (wr_word[4:0] != sel_q);
        end else if (!wr_word.pmode[1]) begin
          phase    <= PH_IDLE;
          tracking <= 1'b0;
        end else if (wr_word.host_acq) begin
          phase    <= PH_ACQ_HOST;
          tracking <= 1'b1;
        end else begin
          phase    <= PH_ACQ_SELF;
          tracking <= 1'b1;
        end
      end else if (tick) begin
        case (phase)
          PH_ACQ_SELF: begin
            if (cnt == ACQ_LAST) begin
              phase      <= PH_CONV;
              cnt        <= '0;
              tracking   <= 1'b0;
              conv_start <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_CONV: begin
            conv_step <= 1'b1;
            if (cnt == CONV_LAST) begin
              phase <= PH_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_ev,
  input  logic              rd_ev,
  input  logic              done_now,
  input  logic              corrupt,
  input  logic [DATA_W-1:0] sar_result,
  output logic [DATA_W-1:0] dout,
  output logic              oe,
  output logic              int_n
);
  logic [DATA_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      int_n <= 1'b1;
    end else if (wr_ev) begin
      int_n <= 1'b1;
    end else if (done_now && !corrupt) begin
      res_q <= sar_result;
      int_n <= 1'b0;
    end else if (rd_ev) begin
      int_n <= 1'b1;
    end
  end

  assign oe   = !cs_n && !rd_n;
  assign dout = res_q;
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int ACQ_TICKS  = 4,
  parameter int CONV_TICKS = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [7:0]        bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              int_n,
  input  logic              ext_tick,
  input  logic              int_tick,
  input  logic [DATA_W-1:0] sar_result,
  output logic              tracking,
  output logic              conv_start,
  output logic              conv_step,
  output logic [2:0]        ch_addr,
  output logic              single_ended,
  output logic              unipolar,
  output logic              clk_ext,
  output logic [1:0]        pwr_state,
  output logic              corrupt
);
  logic       wr_ev, rd_ev, tick, done_now;
  ctrl_t      wr_word;
  logic [4:0] sel_q;
  pwr_e       pwr_q;

  adc_bus_front u_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .ext_tick(ext_tick), .int_tick(int_tick), .use_ext(clk_ext),
    .din(bus_din), .wr_ev(wr_ev), .rd_ev(rd_ev), .wr_word(wr_word),
    .tick(tick)
  );

  adc_seq_core #(.ACQ_TICKS(ACQ_TICKS), .CONV_TICKS(CONV_TICKS)) u_core (
    .clk(clk), .rst(rst), .wr_ev(wr_ev), .wr_word(wr_word), .tick(tick),
    .sel_q(sel_q), .use_ext(clk_ext), .pwr_q(pwr_q), .tracking(tracking),
    .conv_start(conv_start), .conv_step(conv_step), .corrupt(corrupt),
    .done_now(done_now)
  );

  adc_result_port #(.DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_ev(wr_ev),
    .rd_ev(rd_ev), .done_now(done_now), .corrupt(corrupt),
    .sar_result(sar_result), .dout(bus_dout), .oe(bus_oe), .int_n(int_n)
  );

  assign single_ended = sel_q[4];
  assign unipolar     = sel_q[3];
  assign ch_addr      = sel_q[2:0];
  assign pwr_state    = pwr_q;
endmodule

// File: rtl/adc_bus_seq_chk.sv
module adc_bus_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       wr_n,
  input logic       int_n,
  input logic       tracking,
  input logic       conv_start,
  input logic       conv_step,
  input logic [1:0] pwr_state,
  input logic       corrupt
);
  // R7: a write event leaves the interrupt released
  a_r7_write_clears_int: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(wr_n) && wr_n) |=> int_n);

  // R3/R4: the hold instant only follows a tracking interval
  a_r3_start_after_tracking: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(tracking));

  // R3: the interrupt falls together with a conversion step
  a_r3_int_falls_on_step: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> conv_step);

  // R5: a corrupted conversion never raises the interrupt
  a_r5_corrupt_no_int: assert property (@(posedge clk) disable iff (rst)
    corrupt |-> int_n);

  // R11: powered-down states never track
  a_r11_down_not_tracking: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != 2'd0) |-> !tracking);

  // R3: start and step pulses never coincide
  a_r3_start_step_apart: assert property (@(posedge clk) disable iff (rst)
    $onehot0({conv_start, conv_step}));
endmodule

bind adc_bus_seq adc_bus_seq_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .int_n(int_n),
  .tracking(tracking), .conv_start(conv_start), .conv_step(conv_step),
  .pwr_state(pwr_state), .corrupt(corrupt)
);

// File: tb/tb_adc_bus_seq.sv
module tb_adc_bus_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst, cs_n, wr_n, rd_n, ext_tick, int_tick;
  logic [7:0] bus_din;
  logic [DW-1:0] sar_result, bus_dout;
  logic bus_oe, int_n, tracking, conv_start, conv_step;
  logic [2:0] ch_addr;
  logic single_ended, unipolar, clk_ext, corrupt;
  logic [1:0] pwr_state;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_bus_seq dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe), .int_n(int_n),
    .ext_tick(ext_tick), .int_tick(int_tick), .sar_result(sar_result),
    .tracking(tracking), .conv_start(conv_start), .conv_step(conv_step),
    .ch_addr(ch_addr), .single_ended(single_ended), .unipolar(unipolar),
    .clk_ext(clk_ext), .pwr_state(pwr_state), .corrupt(corrupt)
  );

  // {control word, SAR result}; all self-timed, external clock
  localparam logic [19:0] VEC [4] = '{
    {8'hC0, 12'h5A5}, {8'hDD, 12'hFFF}, {8'hCA, 12'h001}, {8'hD3, 12'h800}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_word(input logic [7:0] w);
    @(negedge clk); bus_din = w; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input bit internal);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (internal) int_tick = 1'b1; else ext_tick = 1'b1;
      @(negedge clk);
      int_tick = 1'b0; ext_tick = 1'b0;
    end
  endtask

  task automatic read_check(input string req, input logic [DW-1:0] exp);
    @(negedge clk); rd_n = 1'b0;
    #1;
    chk("R8", "bus_oe during read", 32'(bus_oe), 32'd1);
    chk(req, "bus_dout", 32'(bus_dout), 32'(exp));
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk);
    chk("R7", "int_n after read", 32'(int_n), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cs_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
    ext_tick = 1'b0; int_tick = 1'b0; bus_din = '0; sar_result = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "int_n", 32'(int_n), 32'd1);
    chk("R1", "clk_ext", 32'(clk_ext), 32'd1);
    chk("R1", "pwr_state", 32'(pwr_state), 32'd0);
    chk("R1", "tracking", 32'(tracking), 32'd0);
    chk("R1", "corrupt", 32'(corrupt), 32'd0);
    chk("R1", "bus_oe", 32'(bus_oe), 32'd0);

    // vector walk: R2 decode, R3 self-timed timing, R8 read, R7 release
    for (int v = 0; v < 4; v++) begin
      sar_result = VEC[v][11:0];
      write_word(VEC[v][19:12]);
      chk("R2", "ch_addr", 32'(ch_addr), 32'(VEC[v][14:12]));
      chk("R2", "single_ended", 32'(single_ended), 32'(VEC[v][16]));
      chk("R2", "unipolar", 32'(unipolar), 32'(VEC[v][15]));
      chk("R3", "tracking after write", 32'(tracking), 32'd1);
      ticks(3, 1'b0);
      chk("R3", "tracking after 3 ticks", 32'(tracking), 32'd1);
      ticks(1, 1'b0);
      chk("R3", "tracking after 4 ticks", 32'(tracking), 32'd0);
      ticks(12, 1'b0);
      chk("R3", "int_n after 12 conv ticks", 32'(int_n), 32'd1);
      ticks(1, 1'b0);
      chk("R3", "int_n after 13 conv ticks", 32'(int_n), 32'd0);
      read_check("R3", VEC[v][11:0]);
    end

    // R4 host-timed acquisition
    sar_result = 12'h321;
    write_word(8'hE5);
    ticks(20, 1'b0);
    chk("R4", "tracking held", 32'(tracking), 32'd1);
    chk("R4", "int_n during tracking", 32'(int_n), 32'd1);
    write_word(8'hC5);
    chk("R4", "tracking after closing write", 32'(tracking), 32'd0);
    chk("R5", "corrupt on matching close", 32'(corrupt), 32'd0);
    ticks(12, 1'b0);
    chk("R4", "int_n after 12", 32'(int_n), 32'd1);
    ticks(1, 1'b0);
    chk("R4", "int_n after 13", 32'(int_n), 32'd0);
    read_check("R4", 12'h321);

    // R5 protected field changed on closing write
    sar_result = 12'h777;
    write_word(8'hE5);
    write_word(8'hC6);
    chk("R5", "corrupt", 32'(corrupt), 32'd1);
    ticks(13, 1'b0);
    chk("R5", "int_n stays high", 32'(int_n), 32'd1);
    read_check("R5", 12'h321);

    // R12 closing write with standby code
    sar_result = 12'h444;
    write_word(8'hE5);
    write_word(8'h45);
    chk("R12", "corrupt", 32'(corrupt), 32'd0);
    chk("R12", "pwr_state standby", 32'(pwr_state), 32'd1);
    chk("R10", "clk_ext kept", 32'(clk_ext), 32'd1);
    ticks(13, 1'b0);
    chk("R12", "int_n after conversion", 32'(int_n), 32'd0);
    read_check("R12", 12'h444);

    // R11 shutdown
    write_word(8'h05);
    chk("R11", "pwr_state shutdown", 32'(pwr_state), 32'd2);
    chk("R11", "tracking", 32'(tracking), 32'd0);
    ticks(30, 1'b0);
    chk("R11", "no conversion", 32'(int_n), 32'd1);
    chk("R10", "clk_ext kept in shutdown", 32'(clk_ext), 32'd1);

    // R10 wake with internal clock
    sar_result = 12'h9A9;
    write_word(8'h84);
    chk("R11", "pwr_state active", 32'(pwr_state), 32'd0);
    chk("R10", "clk_ext internal", 32'(clk_ext), 32'd0);
    ticks(25, 1'b0);
    chk("R10", "external ticks ignored", 32'(int_n), 32'd1);
    chk("R10", "still tracking", 32'(tracking), 32'd1);
    ticks(17, 1'b1);
    chk("R10", "internal ticks convert", 32'(int_n), 32'd0);
    read_check("R10", 12'h9A9);

    // R6 abort during conversion
    sar_result = 12'h0F0;
    write_word(8'hC0);
    ticks(10, 1'b0);
    write_word(8'hC1);
    chk("R6", "tracking restarted", 32'(tracking), 32'd1);
    ticks(16, 1'b0);
    chk("R6", "int_n before new end", 32'(int_n), 32'd1);
    ticks(1, 1'b0);
    chk("R6", "int_n at new end", 32'(int_n), 32'd0);
    // R7 write releases interrupt
    write_word(8'hC2);
    chk("R7", "int_n after write", 32'(int_n), 32'd1);
    ticks(17, 1'b0);
    read_check("R6", 12'h0F0);

    // R9 chip select high blocks strobes and ticks
    sar_result = 12'h6B6;
    write_word(8'hC3);
    ticks(5, 1'b0);
    @(negedge clk); cs_n = 1'b1;
    ticks(20, 1'b0);
    chk("R9", "ticks ignored", 32'(int_n), 32'd1);
    write_word(8'h05);
    chk("R9", "write ignored", 32'(pwr_state), 32'd0);
    @(negedge clk); rd_n = 1'b0;
    #1;
    chk("R9", "bus_oe with cs high", 32'(bus_oe), 32'd0);
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    ticks(11, 1'b0);
    chk("R9", "int_n before resumed end", 32'(int_n), 32'd1);
    ticks(1, 1'b0);
    chk("R9", "int_n at resumed end", 32'(int_n), 32'd0);
    read_check("R9", 12'h6B6);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule